// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by combining two predictors. One is a per-address table of 2-bit saturating counters, the bimodal side. The other is a table of the same counters indexed by the global branch history, the global side. A third table of 2-bit saturating counters, the chooser, decides for each lookup which of the two component predictions becomes the final answer. A lookup presents a branch address and the current global history. One cycle later it returns the final direction together with both component predictions.

The front end keeps the two component predictions with the branch. When the branch resolves, it sends them back on the update port with the address, the history that was used and the real outcome. Each update trains both component tables. The chooser entry is trained only when exactly one component was right, and it moves one step toward that component. A parameter selects whether the chooser is indexed by address bits or by history bits.

Top module: `tourney_dir_pred`

## Requirements
- R1: A lookup with `req_vld` high, accepted at a rising edge, sets `rsp_vld` high after that edge for one cycle. Without a lookup, `rsp_vld` is low after the edge.
- R2: The bimodal index is `addr[BIM_IDX_W+1:2]`, so the two low address bits and the bits above the index are ignored. The global index is `hist[GLB_IDX_W-1:0]`. The chooser index is `addr[CH_IDX_W+1:2]` when `CH_BY_HIST`=0 and `hist[CH_IDX_W-1:0]` when it is 1.
- R3: Every counter is 2 bits wide and saturating. A component predicts taken when the top bit of its counter is 1. A taken outcome adds one, stopping at 11, and a not-taken outcome subtracts one, stopping at 00. Component counters reset to 10.
- R4: Each update trains both component tables with the actual outcome, whichever side the chooser selected.
- R5: When the top bit of the chooser counter is 1, `rsp_dir` equals `rsp_glb`. When it is 0, `rsp_dir` equals `rsp_bim`. Chooser counters reset to 01.
- R6: The chooser counter adds one (toward global) when the global prediction was correct and the bimodal one was wrong. It subtracts one when the bimodal prediction was correct and the global one was wrong.
- R7: When both component predictions were correct, or both were wrong, the chooser counter does not change.
- R8: When a lookup and an update use the same entry in the same cycle, the lookup returns the value from before the update.
- R9: While `rsp_vld` is low, including after reset, `rsp_dir`, `rsp_bim` and `rsp_glb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Branch address for the lookup |
| req_hist | input | HIST_W | Global history for the lookup |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_dir | output | 1 | Final predicted direction (1 = taken) |
| rsp_bim | output | 1 | Bimodal component prediction |
| rsp_glb | output | 1 | Global component prediction |
| upd_vld | input | 1 | Resolved branch update |
| upd_addr | input | ADDR_W | Branch address of the resolved branch |
| upd_hist | input | HIST_W | History used when the branch was predicted |
| upd_taken | input | 1 | Actual outcome |
| upd_bim | input | 1 | Bimodal prediction that was given for this branch |
| upd_glb | input | 1 | Global prediction that was given for this branch |

## Verification
Directed sequences build the situations that separate the chooser rules. In one, the global side is right and the bimodal side is wrong until the selection flips. In another, both sides are right, or both wrong, so the selection must not move. Counters are driven into both saturation limits. A lookup and an update hit the same entry in the same cycle. Random traffic then runs over a small pool of addresses and histories, with random high-order bits and predictions returned in every combination. Two instances, one with an address-indexed chooser and one with a history-indexed chooser, are compared against a bench model on every cycle. A wrong index choice, a wrong training rule or wrong saturation shows up as a final direction that differs from the model.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_TAKEN     = 2'b10;
  localparam ctr2_t CTR_WEAK_NOT_TAKEN = 2'b01;

  // One saturating step of a 2-bit counter.
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    ctr2_t n;
    if (up) n = (c == 2'b11) ? c : c + 2'b01;
    else    n = (c == 2'b00) ? c : c - 2'b01;
    return n;
  endfunction

endpackage

// File: rtl/tp_index_sel.sv
module tp_index_sel #(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 12,
  parameter int IDX_W    = 8,
  parameter bit USE_HIST = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  logic unused_src;
  assign unused_src = ^{addr, hist};

  generate
    if (USE_HIST) begin : g_hist
      assign idx = hist[IDX_W-1:0];
    end else begin : g_addr
      assign idx = addr[IDX_W+1:2];
    end
  endgenerate

  initial begin
    assert (IDX_W + 2 <= ADDR_W && IDX_W <= HIST_W)
      else $error("index width too large for source");
  end

endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int    IDX_W = 8,
  parameter ctr2_t INIT  = CTR_WEAK_TAKEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];
  ctr2_t wr_cur;

  assign wr_cur = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rd_ctr <= '0;
    end else begin
      if (wr_en) mem[wr_idx] <= ctr_step(wr_cur, wr_up);
      if (rd_en) rd_ctr <= mem[rd_idx];   // old contents on collision (R8)
    end
  end

  // R3: a counter at the top stays there on another upward step
  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up && wr_cur == 2'b11) |=> (mem[$past(wr_idx)] == 2'b11));

  // R3: a counter at the bottom stays there on another downward step
  assert_sat_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_up && wr_cur == 2'b00) |=> (mem[$past(wr_idx)] == 2'b00));

  // R3 / R6: a written entry below the top rises by exactly one
  assert_step_up_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up && wr_cur != 2'b11) |=> (mem[$past(wr_idx)] == $past(wr_cur) + 2'b01));

endmodule

// File: rtl/tourney_dir_pred.sv
module tourney_dir_pred
  import tp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int HIST_W     = 12,
  parameter int BIM_IDX_W  = 8,
  parameter int GLB_IDX_W  = 8,
  parameter int CH_IDX_W   = 8,
  parameter bit CH_BY_HIST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [HIST_W-1:0] req_hist,
  output logic              rsp_vld,
  output logic              rsp_dir,
  output logic              rsp_bim,
  output logic              rsp_glb,
  input  logic              upd_vld,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  input  logic              upd_bim,
  input  logic              upd_glb
);

  logic [BIM_IDX_W-1:0] bim_rd_idx, bim_wr_idx;
  logic [GLB_IDX_W-1:0] glb_rd_idx, glb_wr_idx;
  logic [CH_IDX_W-1:0]  ch_rd_idx,  ch_wr_idx;
  ctr2_t bim_q, glb_q, ch_q;
  logic  bim_ok, glb_ok, ch_wr, ch_up;
  logic  vld_q;

  // lookup-side index selection
  tp_index_sel #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(BIM_IDX_W), .USE_HIST(1'b0))
    u_bim_rd_ix (.addr(req_addr), .hist(req_hist), .idx(bim_rd_idx));
  tp_index_sel #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(GLB_IDX_W), .USE_HIST(1'b1))
    u_glb_rd_ix (.addr(req_addr), .hist(req_hist), .idx(glb_rd_idx));
  tp_index_sel #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(CH_IDX_W), .USE_HIST(CH_BY_HIST))
    u_ch_rd_ix  (.addr(req_addr), .hist(req_hist), .idx(ch_rd_idx));

  // update-side index selection
  tp_index_sel #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(BIM_IDX_W), .USE_HIST(1'b0))
    u_bim_wr_ix (.addr(upd_addr), .hist(upd_hist), .idx(bim_wr_idx));
  tp_index_sel #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(GLB_IDX_W), .USE_HIST(1'b1))
    u_glb_wr_ix (.addr(upd_addr), .hist(upd_hist), .idx(glb_wr_idx));
  tp_index_sel #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(CH_IDX_W), .USE_HIST(CH_BY_HIST))
    u_ch_wr_ix  (.addr(upd_addr), .hist(upd_hist), .idx(ch_wr_idx));

  // chooser training: only when exactly one side was right (R6, R7)
  assign bim_ok = (upd_bim == upd_taken);
  assign glb_ok = (upd_glb == upd_taken);
  assign ch_wr  = upd_vld && (bim_ok != glb_ok);
  assign ch_up  = glb_ok;

  // component tables train on every update (R4)
  tp_ctr_table #(.IDX_W(BIM_IDX_W), .INIT(CTR_WEAK_TAKEN)) u_bim_tbl (
    .clk(clk), .rst(rst),
    .rd_en(req_vld), .rd_idx(bim_rd_idx), .rd_ctr(bim_q),
    .wr_en(upd_vld), .wr_idx(bim_wr_idx), .wr_up(upd_taken));

  tp_ctr_table #(.IDX_W(GLB_IDX_W), .INIT(CTR_WEAK_TAKEN)) u_glb_tbl (
    .clk(clk), .rst(rst),
    .rd_en(req_vld), .rd_idx(glb_rd_idx), .rd_ctr(glb_q),
    .wr_en(upd_vld), .wr_idx(glb_wr_idx), .wr_up(upd_taken));

  tp_ctr_table #(.IDX_W(CH_IDX_W), .INIT(CTR_WEAK_NOT_TAKEN)) u_ch_tbl (
    .clk(clk), .rst(rst),
    .rd_en(req_vld), .rd_idx(ch_rd_idx), .rd_ctr(ch_q),
    .wr_en(ch_wr), .wr_idx(ch_wr_idx), .wr_up(ch_up));

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= req_vld;
  end

  assign rsp_vld = vld_q;
  assign rsp_bim = vld_q & bim_q[1];
  assign rsp_glb = vld_q & glb_q[1];
  assign rsp_dir = vld_q & (ch_q[1] ? glb_q[1] : bim_q[1]);

  // R1: every accepted lookup produces a response on the next cycle
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);

  // R1 / R9: no lookup, no response, and outputs are quiet
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> (!rsp_vld && !rsp_dir && !rsp_bim && !rsp_glb));

  // R5: the final direction is always one of the two component answers
  assert_dir_from_side_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> (rsp_dir == rsp_bim || rsp_dir == rsp_glb));

  // R5: when both sides agree the final direction cannot differ
  assert_agree_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && rsp_bim == rsp_glb) |-> (rsp_dir == rsp_bim));

endmodule

// File: tb/tourney_dir_pred_tb.sv
`timescale 1ns/1ps
module tourney_dir_pred_tb_top;

  localparam int ADDR_W = 32;
  localparam int HIST_W = 12;
  localparam int IW     = 8;
  localparam int DEPTH  = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              req_vld = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [HIST_W-1:0] req_hist = '0;
  logic              upd_vld = 1'b0, upd_taken = 1'b0, upd_bim = 1'b0, upd_glb = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic [HIST_W-1:0] upd_hist = '0;

  logic vld_a, dir_a, bim_a, glb_a;
  logic vld_h, dir_h, bim_h, glb_h;

  tourney_dir_pred #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .BIM_IDX_W(IW), .GLB_IDX_W(IW),
                     .CH_IDX_W(IW), .CH_BY_HIST(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr), .req_hist(req_hist),
    .rsp_vld(vld_a), .rsp_dir(dir_a), .rsp_bim(bim_a), .rsp_glb(glb_a),
    .upd_vld(upd_vld), .upd_addr(upd_addr), .upd_hist(upd_hist), .upd_taken(upd_taken),
    .upd_bim(upd_bim), .upd_glb(upd_glb));

  tourney_dir_pred #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .BIM_IDX_W(IW), .GLB_IDX_W(IW),
                     .CH_IDX_W(IW), .CH_BY_HIST(1'b1)) dut_h_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr), .req_hist(req_hist),
    .rsp_vld(vld_h), .rsp_dir(dir_h), .rsp_bim(bim_h), .rsp_glb(glb_h),
    .upd_vld(upd_vld), .upd_addr(upd_addr), .upd_hist(upd_hist), .upd_taken(upd_taken),
    .upd_bim(upd_bim), .upd_glb(upd_glb));

  // reference state, built from the requirements
  logic [1:0] m_bim [DEPTH];
  logic [1:0] m_glb [DEPTH];
  logic [1:0] m_cha [DEPTH];
  logic [1:0] m_chh [DEPTH];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic int aidx(logic [ADDR_W-1:0] a);
    return int'(a[IW+1:2]);
  endfunction

  function automatic int hidx(logic [HIST_W-1:0] h);
    return int'(h[IW-1:0]);
  endfunction

  function automatic logic [1:0] step(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got vld/dir/bim/glb=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_bim[i] = 2'b10; m_glb[i] = 2'b10; m_cha[i] = 2'b01; m_chh[i] = 2'b01;
    end
  endtask

  // one clock: drive at negedge, expect from pre-update model, sample after edge
  task automatic cyc(string tag, logic rv, logic [ADDR_W-1:0] ra, logic [HIST_W-1:0] rh,
                     logic uv, logic [ADDR_W-1:0] ua, logic [HIST_W-1:0] uh,
                     logic ut, logic ub, logic ug);
    logic [3:0] ea, eh;
    logic eb, eg;
    req_vld = rv; req_addr = ra; req_hist = rh;
    upd_vld = uv; upd_addr = ua; upd_hist = uh; upd_taken = ut; upd_bim = ub; upd_glb = ug;
    eb = m_bim[aidx(ra)][1];
    eg = m_glb[hidx(rh)][1];
    if (rv) begin
      ea = {1'b1, (m_cha[aidx(ra)][1] ? eg : eb), eb, eg};
      eh = {1'b1, (m_chh[hidx(rh)][1] ? eg : eb), eb, eg};
    end else begin
      ea = 4'b0000; eh = 4'b0000;
    end
    if (uv) begin
      m_bim[aidx(ua)] = step(m_bim[aidx(ua)], ut);
      m_glb[hidx(uh)] = step(m_glb[hidx(uh)], ut);
      if ((ub == ut) != (ug == ut)) begin
        m_cha[aidx(ua)] = step(m_cha[aidx(ua)], ug == ut);
        m_chh[hidx(uh)] = step(m_chh[hidx(uh)], ug == ut);
      end
    end
    @(posedge clk);
    #1;
    check({tag, " addr-chooser"}, {vld_a, dir_a, bim_a, glb_a}, ea);
    check({tag, " hist-chooser"}, {vld_h, dir_h, bim_h, glb_h}, eh);
    @(negedge clk);
  endtask

  task automatic look(string tag, logic [ADDR_W-1:0] a, logic [HIST_W-1:0] h);
    cyc(tag, 1'b1, a, h, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic upd(string tag, logic [ADDR_W-1:0] a, logic [HIST_W-1:0] h,
                     logic t, logic b, logic g);
    cyc(tag, 1'b0, '0, '0, 1'b1, a, h, t, b, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] ra, ua;
    logic [HIST_W-1:0] rh, uh;
    logic ut;
    void'($urandom(32'd20240517));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: quiet outputs after reset
    check("R9 reset", {vld_a, dir_a, bim_a, glb_a}, 4'b0000);
    check("R9 reset", {vld_h, dir_h, bim_h, glb_h}, 4'b0000);

    // R3 R5: fresh entries predict taken, chooser starts on bimodal
    look("R3 R5 fresh", 32'h0000_0040, 12'h031);
    // R1: idle cycle gives no response
    cyc("R1 idle", 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);

    // R6: global right, bimodal wrong, twice: chooser moves to global
    upd("R6 train", 32'h0000_0040, 12'h031, 1'b1, 1'b0, 1'b1);
    upd("R6 train", 32'h0000_0040, 12'h031, 1'b1, 1'b0, 1'b1);
    // R7 R4: both right at another address drives global entry 31 to 00
    for (int i = 0; i < 3; i++) upd("R7 R4 both ok", 32'h0000_0080, 12'h031, 1'b0, 1'b0, 1'b0);
    look("R5 R6 global chosen", 32'h0000_0040, 12'h031);
    // R2: high address bits and low two bits ignored, high history bits ignored
    look("R2 index bits", 32'hABC0_0043, 12'hF31);
    look("R7 chooser unchanged", 32'h0000_0080, 12'h031);

    // R7: both wrong leaves chooser, R6: bimodal right moves it back
    for (int i = 0; i < 3; i++) upd("R7 both wrong", 32'h0000_0040, 12'h031, 1'b0, 1'b1, 1'b1);
    look("R7 after both wrong", 32'h0000_0040, 12'h031);
    for (int i = 0; i < 4; i++) upd("R6 toward bimodal", 32'h0000_0040, 12'h031, 1'b1, 1'b1, 1'b0);
    look("R6 bimodal chosen", 32'h0000_0040, 12'h031);

    // R3: saturation at both ends
    for (int i = 0; i < 5; i++) upd("R3 sat hi", 32'h0000_0100, 12'h055, 1'b1, 1'b1, 1'b1);
    upd("R3 one down", 32'h0000_0100, 12'h055, 1'b0, 1'b1, 1'b1);
    look("R3 after sat hi", 32'h0000_0100, 12'h055);
    for (int i = 0; i < 5; i++) upd("R3 sat lo", 32'h0000_0100, 12'h055, 1'b0, 1'b0, 1'b0);
    upd("R3 one up", 32'h0000_0100, 12'h055, 1'b1, 1'b0, 1'b0);
    look("R3 after sat lo", 32'h0000_0100, 12'h055);

    // R8: lookup and update of the same entry in one cycle
    cyc("R8 collision", 1'b1, 32'h0000_0200, 12'h077,
        1'b1, 32'h0000_0200, 12'h077, 1'b0, 1'b1, 1'b1);
    look("R8 after collision", 32'h0000_0200, 12'h077);

    // random mixed traffic over a small pool, R2 R4 R6 R7
    for (int n = 0; n < 4000; n++) begin
      ra = (ADDR_W'($urandom % 6) << 2) | ADDR_W'($urandom % 4) | (ADDR_W'($urandom % 8) << 20);
      rh = HIST_W'($urandom % 5) | (HIST_W'($urandom % 16) << 8);
      ua = (ADDR_W'($urandom % 6) << 2) | (ADDR_W'($urandom % 8) << 24);
      uh = HIST_W'($urandom % 5) | (HIST_W'($urandom % 16) << 8);
      ut = ua[2] ^ uh[0] ^ (($urandom % 8) == 0);
      cyc("R2 R4 R6 R7 random", ($urandom % 4) != 0, ra, rh,
          ($urandom % 3) != 0, ua, uh, ut, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule